// File: doc/BRIEF.md
# Register Access Violation Monitor

This block sits beside a small peripheral register bus and watches every access made by software. Each access carries a byte address, a read strobe and a write strobe. The block sorts each improper access into one of a few typed cases: a read of a write-only register, a write to a read-only register, an access to an offset with no register behind it, and a write to a configuration register after the memory device has been brought up. Brought up means that the refresh count is nonzero. The first three cases are warnings and the last is an error. A write to a register that is locked by the write-protect enable is also caught, and is reported on its own as a protection violation.

The block keeps a read-only 32-bit status word. It holds sticky flags and the offset of the first offending access. One shared 8-bit capture field shows the offset of the blocked write when a protection violation is held, and the offset of the bad software access otherwise. Two event inputs set a sequencer-error flag and a clock-glitch flag. A bus read of the status word's own offset clears every field one cycle later. An event that lands in the same cycle as that read survives the clear.

The capture logic is a four-state machine. **ST_CLEAN** holds nothing. **ST_SWERR** holds a software error. **ST_WPVIO** holds a protection violation. **ST_BOTH** holds both. The transitions are named as follows:
- **T_SWE** adds a software error.
- **T_WPV** adds a protection violation.
- **T_CLR** is a status read with no new event, and it returns to ST_CLEAN.
- **T_CLR_SET** is a status read in the same cycle as a new event, and it moves to the state that the event alone selects.
- **T_HOLD** covers every other cycle.

The access kind of each word offset comes from parameter tables, as does membership of the write-protected set and of the configuration set.

Top module: `regviol_monitor`

## Requirements
- R1: After reset the status word is all zero.
- R2: A read (bus_rd=1, bus_wr=0) of a write-only offset sets bit 3 and sets bits 26:24 to 0. Bit 31 stays 0 and bits 15:8 hold the address. Default map: 0x0C is write-only.
- R3: A write to a read-only offset sets bit 3 with type 1, warning class. The status offset 0x40 is itself read-only, so a write to it changes no other status field. Default map: 0x10 and 0x40 are read-only.
- R4: A read or a write to an undefined offset sets bit 3 with type 2, warning class. Undefined means that the table marks the word unused or that address bits 1:0 are nonzero.
- R5: A write to a configuration offset (default 0x00, 0x04, 0x08) while refresh_count is nonzero sets bit 3 with type 3 and sets bit 31 to 1. The same write with refresh_count zero, or a write to a non-configuration read-write offset (default 0x14), raises nothing.
- R6: A write to a write-protected offset (default 0x00, 0x04, 0x08, 0x14) while wp_enable=1 sets bit 0 and puts the offset in bits 15:8. It does not set bit 3 for that access.
- R7: The first software error and the first protection violation since the last clear are kept. Later events of the same kind do not replace them. Bits 15:8 show the protection offset whenever bit 0 is set, and otherwise show the software-error offset.
- R8: A read of offset 0x40 clears bits 31, 26:24, 15:8, 3, 2, 1 and 0 in the following cycle.
- R9: An event in the same cycle as a status read is not lost: its flag is set after the clear.
- R10: seq_err_evt sets bit 2 and clk_glitch_evt sets bit 1. Both flags stay set until a status read.
- R11: Legal accesses raise no flag. These are reads of read-write and read-only offsets, writes to read-write offsets with no protection or configuration rule hit, and cycles with no strobe.
- R12: When bus_rd and bus_wr are both 1, only the write is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| wp_enable | input | 1 | Locks the write-protected offsets |
| refresh_count | input | 12 | Refresh count; nonzero means the device is initialised |
| seq_err_evt | input | 1 | Sequencer-error event |
| clk_glitch_evt | input | 1 | Clock-glitch event |
| status_word | output | 32 | Read-only status word |

## Verification
The bench sends a software error and then a protection violation, and also the reverse order. A design that lets the shared field follow the latest event, or never hands it back to the software address, shows the wrong offset. It also sends repeated errors of the same kind between clears, which catches a design that overwrites the first capture. Events arrive in the same cycle as a status read, so a clear that beats the set drops the flag. Other cases cover configuration writes with zero and nonzero refresh counts, misaligned addresses, writes to the status word itself and simultaneous read and write strobes. A design that gets any of these wrong raises a flag where none belongs, or reports the wrong type or class.

// File: rtl/regviol_pkg.sv
package regviol_pkg;

    typedef enum logic [1:0] {
        ACC_UNDEF = 2'd0,
        ACC_RW    = 2'd1,
        ACC_RO    = 2'd2,
        ACC_WO    = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        ETY_RD_WO   = 3'd0,
        ETY_WR_RO   = 3'd1,
        ETY_UNDEF   = 3'd2,
        ETY_CFG_WR  = 3'd3
    } err_type_e;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_SWERR = 2'd1,
        ST_WPVIO = 2'd2,
        ST_BOTH  = 2'd3
    } cap_state_e;

endpackage

// File: rtl/regviol_decode.sv
module regviol_decode
    import regviol_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 12,
    parameter logic [2**(ADDR_W-1)-1:0] ACC_TABLE = '0,
    parameter logic [2**(ADDR_W-2)-1:0] WP_MASK   = '0,
    parameter logic [2**(ADDR_W-2)-1:0] CFG_MASK  = '0,
    parameter logic [ADDR_W-1:0]        STAT_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              wp_enable,
    input  logic [CNT_W-1:0]  refresh_count,
    output logic              swe_hit,
    output err_type_e         swe_type,
    output logic              swe_class,
    output logic              wp_hit,
    output logic              stat_rd
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    acc_kind_e         kind;
    logic              rd_only;
    logic              dev_ready;

    assign word      = addr[ADDR_W-1:2];
    assign aligned   = (addr[1:0] == 2'b00);
    assign kind      = aligned ? acc_kind_e'(ACC_TABLE[2*int'(word) +: 2]) : ACC_UNDEF;
    assign rd_only   = rd && !wr;
    assign dev_ready = (refresh_count != '0);
    assign stat_rd   = rd_only && (addr == STAT_ADDR);

    always_comb begin
        swe_hit   = 1'b0;
        swe_type  = ETY_RD_WO;
        swe_class = 1'b0;
        wp_hit    = 1'b0;
        if (wr) begin
            if (kind != ACC_UNDEF && wp_enable && WP_MASK[word]) begin
                wp_hit = 1'b1;
            end else if (kind == ACC_UNDEF) begin
                swe_hit  = 1'b1;
                swe_type = ETY_UNDEF;
            end else if (kind == ACC_RO) begin
                swe_hit  = 1'b1;
                swe_type = ETY_WR_RO;
            end else if (CFG_MASK[word] && dev_ready) begin
                swe_hit   = 1'b1;
                swe_type  = ETY_CFG_WR;
                swe_class = 1'b1;
            end
        end else if (rd_only) begin
            if (kind == ACC_UNDEF) begin
                swe_hit  = 1'b1;
                swe_type = ETY_UNDEF;
            end else if (kind == ACC_WO) begin
                swe_hit  = 1'b1;
                swe_type = ETY_RD_WO;
            end
        end
    end

    // R6: a blocked write never also counts as a software error
    always_comb begin
        a_r6_wp_exclusive: assert (!(wp_hit && swe_hit));
    end

endmodule

// File: rtl/regviol_capture.sv
module regviol_capture
    import regviol_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clr,
    input  logic              swe_hit,
    input  err_type_e         swe_type,
    input  logic              swe_class,
    input  logic              wp_hit,
    output logic              swe_flag,
    output logic              wp_flag,
    output logic              err_class,
    output logic [2:0]        err_type,
    output logic [ADDR_W-1:0] offset_field
);

    cap_state_e        state_q, state_d;
    logic              swe_held, wp_held;
    logic              swe_keep, wp_keep;
    logic              swe_take, wp_take;
    logic [ADDR_W-1:0] swe_addr_q, wp_addr_q;
    err_type_e         type_q;
    logic              class_q;

    always_comb begin
        unique case (state_q)
            ST_CLEAN: begin swe_held = 1'b0; wp_held = 1'b0; end
            ST_SWERR: begin swe_held = 1'b1; wp_held = 1'b0; end
            ST_WPVIO: begin swe_held = 1'b0; wp_held = 1'b1; end
            ST_BOTH:  begin swe_held = 1'b1; wp_held = 1'b1; end
            default:  begin swe_held = 1'b0; wp_held = 1'b0; end
        endcase
    end

    assign swe_keep = swe_held && !clr;
    assign wp_keep  = wp_held && !clr;
    assign swe_take = swe_hit && !swe_keep;
    assign wp_take  = wp_hit && !wp_keep;

    // next state: T_HOLD, T_SWE, T_WPV, T_CLR, T_CLR_SET
    always_comb begin
        unique case ({swe_keep || swe_hit, wp_keep || wp_hit})
            2'b00:   state_d = ST_CLEAN;
            2'b10:   state_d = ST_SWERR;
            2'b01:   state_d = ST_WPVIO;
            2'b11:   state_d = ST_BOTH;
            default: state_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swe_addr_q <= '0;
            wp_addr_q  <= '0;
            type_q     <= ETY_RD_WO;
            class_q    <= 1'b0;
        end else begin
            if (swe_take) begin
                swe_addr_q <= addr;
                type_q     <= swe_type;
                class_q    <= swe_class;
            end
            if (wp_take) begin
                wp_addr_q <= addr;
            end
        end
    end

    always_comb begin
        swe_flag     = 1'b0;
        wp_flag      = 1'b0;
        err_class    = 1'b0;
        err_type     = 3'd0;
        offset_field = '0;
        unique case (state_q)
            ST_CLEAN: begin
            end
            ST_SWERR: begin
                swe_flag     = 1'b1;
                err_class    = class_q;
                err_type     = type_q;
                offset_field = swe_addr_q;
            end
            ST_WPVIO: begin
                wp_flag      = 1'b1;
                offset_field = wp_addr_q;
            end
            ST_BOTH: begin
                swe_flag     = 1'b1;
                wp_flag      = 1'b1;
                err_class    = class_q;
                err_type     = type_q;
                offset_field = wp_addr_q;
            end
            default: begin
            end
        endcase
    end

    // R7: a held software-error capture is not replaced until a clear
    a_r7_first_swe_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (swe_flag && !clr) |=> ($stable(offset_field) || wp_flag) && $stable(err_type));

    // R8: a status read with no new event empties the captures
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !swe_hit && !wp_hit) |=> (!swe_flag && !wp_flag && offset_field == '0));

    // R9: an event is visible in the following cycle, even during a clear
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (swe_hit || wp_hit) |=> (swe_flag || wp_flag));

endmodule

// File: rtl/regviol_flags.sv
module regviol_flags #(
    parameter int NUM_EVT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_EVT-1:0] evt,
    output logic [NUM_EVT-1:0] flag
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag[i] <= 1'b0;
            end else if (evt[i]) begin
                flag[i] <= 1'b1;
            end else if (clr) begin
                flag[i] <= 1'b0;
            end
        end

        // R10: the flag follows its event and stays until cleared
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] || (flag[i] && !clr)) |=> flag[i]);
    end

endmodule

// File: rtl/regviol_monitor.sv
module regviol_monitor
    import regviol_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 12,
    parameter logic [2**(ADDR_W-1)-1:0] ACC_TABLE = 128'h2_0000_06D5,
    parameter logic [2**(ADDR_W-2)-1:0] WP_MASK   = 64'h27,
    parameter logic [2**(ADDR_W-2)-1:0] CFG_MASK  = 64'h07,
    parameter logic [ADDR_W-1:0]        STAT_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              wp_enable,
    input  logic [CNT_W-1:0]  refresh_count,
    input  logic              seq_err_evt,
    input  logic              clk_glitch_evt,
    output logic [31:0]       status_word
);

    logic              swe_hit, swe_class, wp_hit, stat_rd;
    err_type_e         swe_type;
    logic              swe_flag, wp_flag, err_class;
    logic [2:0]        err_type;
    logic [ADDR_W-1:0] offset_field;
    logic [1:0]        ev_flag;

    regviol_decode #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ACC_TABLE(ACC_TABLE),
        .WP_MASK(WP_MASK), .CFG_MASK(CFG_MASK), .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wp_enable(wp_enable),
        .refresh_count(refresh_count), .swe_hit(swe_hit), .swe_type(swe_type),
        .swe_class(swe_class), .wp_hit(wp_hit), .stat_rd(stat_rd)
    );

    regviol_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .clr(stat_rd),
        .swe_hit(swe_hit), .swe_type(swe_type), .swe_class(swe_class),
        .wp_hit(wp_hit), .swe_flag(swe_flag), .wp_flag(wp_flag),
        .err_class(err_class), .err_type(err_type), .offset_field(offset_field)
    );

    regviol_flags #(.NUM_EVT(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(stat_rd),
        .evt({seq_err_evt, clk_glitch_evt}), .flag(ev_flag)
    );

    always_comb begin
        status_word        = '0;
        status_word[31]    = err_class;
        status_word[26:24] = err_type;
        status_word[15:8]  = offset_field;
        status_word[3]     = swe_flag;
        status_word[2]     = ev_flag[1];
        status_word[1]     = ev_flag[0];
        status_word[0]     = wp_flag;
    end

    // R5: the error class is only ever paired with the after-init type
    a_r5_class_type: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[31] |-> (status_word[26:24] == 3'd3 && status_word[3]));

    // R1: nothing is reported before any access or event reaches the block
    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_word) == 32'd0 && !$past(bus_rd) && !$past(bus_wr)
         && !$past(seq_err_evt) && !$past(clk_glitch_evt)) |-> status_word == 32'd0);

endmodule

// File: tb/regviol_monitor_bench.sv
module regviol_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, wp_enable = 1'b0;
    logic [11:0] refresh_count = '0;
    logic        seq_err_evt = 1'b0, clk_glitch_evt = 1'b0;
    logic [31:0] status_word;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // reference state
    bit       m_swe, m_wp, m_seq, m_cgd, m_class;
    int       m_type, m_sweaddr, m_wpaddr;

    always #2.5 clk = ~clk;

    regviol_monitor u_regviol_monitor (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .wp_enable(wp_enable), .refresh_count(refresh_count),
        .seq_err_evt(seq_err_evt), .clk_glitch_evt(clk_glitch_evt),
        .status_word(status_word)
    );

    // 0 undefined, 1 read-write, 2 read-only, 3 write-only
    function automatic int kind_of(int a);
        if (a % 4 != 0) return 0;
        case (a / 4)
            0, 1, 2, 5: return 1;
            3:          return 3;
            4, 16:      return 2;
            default:    return 0;
        endcase
    endfunction

    function automatic bit is_wp(int a);
        return (a == 0 || a == 4 || a == 8 || a == 20);
    endfunction

    function automatic bit is_cfg(int a);
        return (a == 0 || a == 4 || a == 8);
    endfunction

    function automatic logic [31:0] expected();
        logic [31:0] w;
        w = '0;
        w[31]    = m_class;
        w[26:24] = m_type[2:0];
        w[15:8]  = m_wp ? m_wpaddr[7:0] : (m_swe ? m_sweaddr[7:0] : 8'd0);
        w[3] = m_swe; w[2] = m_seq; w[1] = m_cgd; w[0] = m_wp;
        return w;
    endfunction

    task automatic model_clear();
        m_swe = 0; m_wp = 0; m_seq = 0; m_cgd = 0; m_class = 0;
        m_type = 0; m_sweaddr = 0; m_wpaddr = 0;
    endtask

    task automatic model_update(int a, bit rd, bit wr, bit sq, bit cg);
        bit hs, hw, cls; int ty; int k;
        hs = 0; hw = 0; cls = 0; ty = 0;
        k = kind_of(a);
        if (wr) begin
            if (k != 0 && wp_enable && is_wp(a)) hw = 1;
            else if (k == 0) begin hs = 1; ty = 2; end
            else if (k == 2) begin hs = 1; ty = 1; end
            else if (is_cfg(a) && refresh_count != 0) begin hs = 1; ty = 3; cls = 1; end
        end else if (rd) begin
            if (k == 0) begin hs = 1; ty = 2; end
            else if (k == 3) begin hs = 1; ty = 0; end
        end
        if (rd && !wr && a == 'h40) model_clear();
        if (sq) m_seq = 1;
        if (cg) m_cgd = 1;
        if (hw && !m_wp) begin m_wp = 1; m_wpaddr = a; end
        if (hs && !m_swe) begin m_swe = 1; m_type = ty; m_class = cls; m_sweaddr = a; end
    endtask

    task automatic compare(string tag);
        logic [31:0] e;
        e = expected();
        vectors++;
        if (status_word !== e) begin
            miscompares++;
            $display("FAIL %s actual=%08h expected=%08h", tag, status_word, e);
        end
    endtask

    task automatic step(string tag, int a, bit rd, bit wr, bit sq = 0, bit cg = 0);
        @(negedge clk);
        bus_addr = a[7:0]; bus_rd = rd; bus_wr = wr;
        seq_err_evt = sq; clk_glitch_evt = cg;
        @(posedge clk);
        model_update(a, rd, wr, sq, cg);
        #1;
        compare(tag);
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; seq_err_evt = 0; clk_glitch_evt = 0;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0);
    endtask

    task automatic clear_status(string tag);
        step(tag, 'h40, 1, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");

        // R11 legal traffic
        step("R11", 'h00, 1, 0);
        step("R11", 'h00, 0, 1);
        step("R11", 'h10, 1, 0);
        step("R11", 'h14, 0, 1);
        clear_status("R11");
        idle("R11");

        // R2 read of write-only
        step("R2", 'h0C, 1, 0);
        idle("R2");
        clear_status("R8");
        idle("R8");

        // R3 write read-only, then the status word itself; first kept (R7)
        step("R3", 'h10, 0, 1);
        step("R3", 'h40, 0, 1);
        clear_status("R8");
        step("R3", 'h40, 0, 1);
        clear_status("R8");

        // R4 undefined and misaligned
        step("R4", 'h20, 1, 0);
        clear_status("R8");
        step("R4", 'h41, 0, 1);
        clear_status("R8");
        step("R4", 'hFC, 1, 0);
        clear_status("R8");

        // R5 configuration write after init
        refresh_count = 12'd5;
        step("R5", 'h14, 0, 1);
        step("R5", 'h04, 0, 1);
        idle("R5");
        clear_status("R8");
        refresh_count = 12'd0;
        step("R5", 'h04, 0, 1);
        idle("R5");

        // R6 / R7 protection violation
        wp_enable = 1'b1;
        step("R6", 'h08, 0, 1);
        step("R7", 'h14, 0, 1);
        step("R7", 'h0C, 1, 0);
        idle("R7");
        clear_status("R8");
        idle("R8");
        step("R7", 'h0C, 1, 0);
        step("R7", 'h10, 0, 1);
        step("R7", 'h00, 0, 1);
        refresh_count = 12'd1;
        step("R6", 'h04, 0, 1);
        clear_status("R8");
        step("R6", 'h04, 0, 1);
        wp_enable = 1'b0;
        clear_status("R8");
        refresh_count = 12'd0;

        // R10 event flags
        step("R10", 0, 0, 0, 1, 0);
        idle("R10");
        step("R10", 0, 0, 0, 0, 1);
        step("R10", 'h00, 1, 0);
        clear_status("R8");
        idle("R8");

        // R9 events in the clearing cycle
        step("R9", 0, 0, 0, 1, 1);
        step("R9", 'h40, 1, 0, 1, 0);
        idle("R9");
        step("R9", 'h40, 1, 0, 0, 1);
        idle("R9");
        clear_status("R8");

        // R12 read and write together
        step("R12", 'h0C, 1, 1);
        idle("R12");
        step("R12", 'h10, 1, 1);
        step("R12", 'h40, 1, 1);
        idle("R12");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule